// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block guards a shared two-port memory of 2^ADDR_W bytes against simultaneous access to one location. Each port presents an active-low select, an address and an active-low write strobe. Every clock the block registers both ports and checks whether both are selected on the same address. On a collision one port keeps its access and the other receives an active-low busy indication. The write enable that the losing port would send to the array is suppressed. Whether a port is reading or writing plays no part in the decision.

The block has two modes. In master mode it makes the decision and drives it on its busy outputs. In slave mode it makes no decision of its own. Its busy outputs stay high, and externally supplied busy inputs, normally wired from one master, act only as write inhibits. Several devices placed side by side for a wider word therefore obey one shared decision.

Top module: `dpram_collision_arbiter`

## Requirements
- R1: In master mode both busy outputs are high unless, in the registered view, both selects are low and the two addresses are equal.
- R2: When one port was already selected on an address and the other port then selects the same address, the port that arrived later is the one made busy (left busy low when the right port won, right busy low when the left port won).
- R3: When both ports start a colliding access in the same cycle, the left port wins and the right busy output goes low.
- R4: The two busy outputs are never low at the same time.
- R5: The write strobes have no effect on which port is made busy; a colliding pair of reads is arbitrated exactly like a pair of writes.
- R6: A port's write enable output is high only for a registered request with select low and write strobe low, and only when that port's effective busy is high. In master mode the effective busy is the port's own busy output, and a write from a busy port never reaches the array.
- R7: Once made, a decision holds for as long as neither port changes its select or its address.
- R8: When the collision disappears, busy is released on the following clock edge.
- R9: In slave mode both busy outputs stay high. The busy input of each port (low = inhibit) gates only that port's writes. An input held low blocks every write on that port, and an input held high lets writes through.
- R10: Busy and write enable outputs reflect the port inputs sampled two rising edges earlier. The slave busy inputs act on the write enables at once, without a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1 = follow external busy inputs, 0 = arbitrate |
| l_ce_n | input | 1 | Left select, active low |
| l_addr | input | ADDR_W | Left address |
| l_we_n | input | 1 | Left write strobe, active low |
| r_ce_n | input | 1 | Right select, active low |
| r_addr | input | ADDR_W | Right address |
| r_we_n | input | 1 | Right write strobe, active low |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_wr_en | output | 1 | Left write enable to the array |
| r_wr_en | output | 1 | Right write enable to the array |

## Verification
A port change applied between edges appears on the busy and write enable outputs after the second rising edge that follows it. An external busy input changes the write enables in the same cycle. The bench drives inputs 1 ns after a rising edge and keeps a cycle-true model with the same two register stages. It compares every output 1 ns after each edge, so each result is read in the cycle it becomes due. Sweeps cover every address pair from a small set, every select and strobe combination, and the order of arrival, and they are followed by a long random run.

// File: rtl/dpa_pkg.sv
// Shared types for the collision arbiter.
package dpa_pkg;
    // Which port currently holds a contested location.
    typedef enum logic [1:0] {
        OWNER_NONE  = 2'd0,
        OWNER_LEFT  = 2'd1,
        OWNER_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpa_port_stage.sv
// Input register for one port.
// Holds the current and previous sampled select/address, flags a change
// between them, and forms the raw write request.
// Assumes inputs are synchronous to clk.
module dpa_port_stage #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_n,
    output logic              sel,
    output logic [ADDR_W-1:0] addr_q,
    output logic              fresh,
    output logic              wr_req
);
    logic              ce_n_q, we_n_q, ce_n_p;
    logic [ADDR_W-1:0] addr_p;

    // Sample the port and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n_q <= 1'b1;
            we_n_q <= 1'b1;
            addr_q <= '0;
            ce_n_p <= 1'b1;
            addr_p <= '0;
        end else begin
            ce_n_p <= ce_n_q;
            addr_p <= addr_q;
            ce_n_q <= ce_n;
            we_n_q <= we_n;
            addr_q <= addr;
        end
    end

    // Decode selection, change and write request.
    always_comb begin
        sel    = !ce_n_q;
        fresh  = (ce_n_q != ce_n_p) || (addr_q != addr_p);
        wr_req = !ce_n_q && !we_n_q;
    end
endmodule

// File: rtl/dpa_arbiter.sv
// Collision decision.
// Compares the registered addresses of both ports and decides which port
// holds a shared location: the earlier arrival, the left port on a tie.
// The decision is held while neither port changes.
module dpa_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_l,
    input  logic              sel_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              fresh_l,
    input  logic              fresh_r,
    output owner_e            owner
);
    logic   match;
    owner_e owner_d;

    // Work out the next owner from the current registered view.
    always_comb begin
        match = sel_l && sel_r && (addr_l == addr_r);
        if (!match)
            owner_d = OWNER_NONE;
        else if (owner != OWNER_NONE && !fresh_l && !fresh_r)
            owner_d = owner;
        else if (fresh_l && !fresh_r)
            owner_d = OWNER_RIGHT;
        else
            owner_d = OWNER_LEFT;
    end

    // Hold the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) owner <= OWNER_NONE;
        else        owner <= owner_d;
    end

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_l && sel_r && addr_l == addr_r) |=> owner == OWNER_NONE);
    // R2
    late_left_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_l && sel_r && addr_l == addr_r && fresh_l && !fresh_r) |=> owner == OWNER_RIGHT);
    // R3
    tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_l && sel_r && addr_l == addr_r && fresh_l && fresh_r) |=> owner == OWNER_LEFT);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_l && sel_r && addr_l == addr_r && !fresh_l && !fresh_r && owner != OWNER_NONE)
        |=> $stable(owner));
endmodule

// File: rtl/dpa_write_gate.sv
// Write gate for one port.
// Delays the write request by one stage so it lines up with the busy
// decision, then passes it only while the effective busy is high.
module dpa_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic busy_eff_n,
    output logic wr_en
);
    logic req_q;

    // Align the request with the decision stage.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= wr_req;
    end

    // Suppress the write while busy.
    always_comb wr_en = req_q && busy_eff_n;
endmodule

// File: rtl/dpram_collision_arbiter.sv
// Top: two port stages, one arbiter and two write gates.
// Master mode drives the decision out; slave mode drives busy high and
// gates writes with the external busy inputs.
module dpram_collision_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_ce_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we_n,
    input  logic              r_ce_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we_n,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_en,
    output logic              r_wr_en
);
    localparam int NPORT = 2;

    logic              ce_in   [NPORT];
    logic              we_in   [NPORT];
    logic [ADDR_W-1:0] addr_in [NPORT];
    logic              bin_n   [NPORT];
    logic              sel     [NPORT];
    logic              fresh   [NPORT];
    logic              wr_req  [NPORT];
    logic [ADDR_W-1:0] addr_q  [NPORT];
    logic              busy_m_n[NPORT];
    logic              busy_e_n[NPORT];
    logic              wr_en   [NPORT];
    owner_e            owner;

    // Gather ports into arrays.
    always_comb begin
        ce_in[0] = l_ce_n;  ce_in[1] = r_ce_n;
        we_in[0] = l_we_n;  we_in[1] = r_we_n;
        addr_in[0] = l_addr; addr_in[1] = r_addr;
        bin_n[0] = l_busy_in_n; bin_n[1] = r_busy_in_n;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_port_stage #(.ADDR_W(ADDR_W)) u_stage (
            .clk(clk), .rst_n(rst_n), .ce_n(ce_in[p]), .addr(addr_in[p]),
            .we_n(we_in[p]), .sel(sel[p]), .addr_q(addr_q[p]),
            .fresh(fresh[p]), .wr_req(wr_req[p])
        );
        dpa_write_gate u_gate (
            .clk(clk), .rst_n(rst_n), .wr_req(wr_req[p]),
            .busy_eff_n(busy_e_n[p]), .wr_en(wr_en[p])
        );
    end

    dpa_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .sel_l(sel[0]), .sel_r(sel[1]),
        .addr_l(addr_q[0]), .addr_r(addr_q[1]),
        .fresh_l(fresh[0]), .fresh_r(fresh[1]),
        .owner(owner)
    );

    // Decode the decision and select the effective busy per mode.
    always_comb begin
        busy_m_n[0] = (owner != OWNER_RIGHT);
        busy_m_n[1] = (owner != OWNER_LEFT);
        for (int p = 0; p < NPORT; p++)
            busy_e_n[p] = slave_mode ? bin_n[p] : busy_m_n[p];
        l_busy_n = slave_mode ? 1'b1 : busy_m_n[0];
        r_busy_n = slave_mode ? 1'b1 : busy_m_n[1];
        l_wr_en  = wr_en[0];
        r_wr_en  = wr_en[1];
    end

    // R4
    never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_n || r_busy_n);
    // R9
    slave_busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (l_busy_n && r_busy_n));
    // R6
    busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && (!l_busy_n || !r_busy_n)) |-> !(!l_busy_n && l_wr_en) && !(!r_busy_n && r_wr_en));
    // R10
    write_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr_en |-> $past(!l_ce_n && !l_we_n, 2));
endmodule

// File: tb/tb_dpram_collision_arbiter.sv
module tb_dpram_collision_arbiter;
    localparam int AW = 10;

    logic clk = 0, rst_n = 0, slave_mode = 0;
    logic l_ce_n = 1, l_we_n = 1, r_ce_n = 1, r_we_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_busy_in_n = 1, r_busy_in_n = 1;
    logic l_busy_n, r_busy_n, l_wr_en, r_wr_en;

    int n_chk = 0, n_fail = 0;

    // Cycle-true expectation built from the requirements.
    logic          mc_ce[2], mp_ce[2], m_we[2], m_req[2];
    logic [AW-1:0] mc_a[2], mp_a[2];
    int            m_own;

    always #2.5 clk = ~clk;

    dpram_collision_arbiter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_ce_n(l_ce_n), .l_addr(l_addr), .l_we_n(l_we_n),
        .r_ce_n(r_ce_n), .r_addr(r_addr), .r_we_n(r_we_n),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            mc_ce[p] = 1; mp_ce[p] = 1; m_req[p] = 0;
            mc_a[p] = '0; mp_a[p] = '0;
        end
        m_own = 0;
    endtask

    // One clock: advance the expectation and compare all outputs.
    task automatic step(input string tag);
        logic match, nl, nr, eb_l, eb_r, ef_l, ef_r;
        int own_n;
        logic rq[2];
        @(posedge clk);
        match = !mc_ce[0] && !mc_ce[1] && (mc_a[0] == mc_a[1]);
        nl = (mc_ce[0] != mp_ce[0]) || (mc_a[0] != mp_a[0]);
        nr = (mc_ce[1] != mp_ce[1]) || (mc_a[1] != mp_a[1]);
        if (!match) own_n = 0;
        else if (m_own != 0 && !nl && !nr) own_n = m_own;
        else if (nl && !nr) own_n = 2;
        else own_n = 1;
        for (int p = 0; p < 2; p++) begin
            rq[p] = !mc_ce[p] && !m_we[p];
            mp_ce[p] = mc_ce[p]; mp_a[p] = mc_a[p];
        end
        mc_ce[0] = l_ce_n; mc_a[0] = l_addr; m_we[0] = l_we_n;
        mc_ce[1] = r_ce_n; mc_a[1] = r_addr; m_we[1] = r_we_n;
        m_own = own_n; m_req[0] = rq[0]; m_req[1] = rq[1];
        #1;
        eb_l = slave_mode ? 1'b1 : (m_own != 2);
        eb_r = slave_mode ? 1'b1 : (m_own != 1);
        ef_l = slave_mode ? l_busy_in_n : eb_l;
        ef_r = slave_mode ? r_busy_in_n : eb_r;
        chk(l_busy_n === eb_l, {tag, " l_busy_n"}, l_busy_n, eb_l);
        chk(r_busy_n === eb_r, {tag, " r_busy_n"}, r_busy_n, eb_r);
        chk(l_wr_en === (m_req[0] && ef_l), {tag, " l_wr_en"}, l_wr_en, m_req[0] && ef_l);
        chk(r_wr_en === (m_req[1] && ef_r), {tag, " r_wr_en"}, r_wr_en, m_req[1] && ef_r);
        // R4: never both busy
        chk(l_busy_n || r_busy_n, "R4 both busy", 0, 1);
    endtask

    task automatic idle();
        l_ce_n = 1; r_ce_n = 1; l_we_n = 1; r_we_n = 1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_we[0] = 1; m_we[1] = 1;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1: reset state
        chk(l_busy_n && r_busy_n && !l_wr_en && !r_wr_en, "R1 reset state", l_busy_n, 1);

        // R2: left arrives first, right collides later and loses
        l_ce_n = 0; l_addr = 10'd5; l_we_n = 0; step("R2 left early");
        r_ce_n = 0; r_addr = 10'd5; r_we_n = 0; step("R2 right joins");
        step("R2 decide");
        step("R2 settle");
        chk(!r_busy_n && l_busy_n, "R2 right busy", r_busy_n, 0);
        chk(!r_wr_en && l_wr_en, "R6 right write blocked", r_wr_en, 0);
        // R7: hold while stable
        repeat (4) step("R7 hold");
        chk(!r_busy_n, "R7 still held", r_busy_n, 0);
        // R8: left moves away, release next cycle
        l_addr = 10'd6; step("R8 move"); step("R8 release");
        chk(l_busy_n && r_busy_n, "R8 released", r_busy_n, 1);
        idle(); repeat (3) step("idle");

        // R2: right first, left later loses
        r_ce_n = 0; r_addr = 10'd9; step("R2 right early");
        l_ce_n = 0; l_addr = 10'd9; l_we_n = 0; step("R2 left joins");
        step("R2 decide"); step("R2 settle");
        chk(!l_busy_n && !l_wr_en, "R2 left busy, R6 write blocked", l_busy_n, 0);
        idle(); repeat (3) step("idle");

        // R3 and R5: simultaneous start under every strobe pair
        for (int w = 0; w < 4; w++) begin
            l_ce_n = 0; r_ce_n = 0; l_addr = 10'd3; r_addr = 10'd3;
            l_we_n = w[0]; r_we_n = w[1];
            step("R3 start"); step("R5 decide"); step("R3 settle");
            chk(!r_busy_n && l_busy_n, "R3 R5 left wins tie", r_busy_n, 0);
            idle(); repeat (2) step("R8 idle");
        end

        // R1 sweep: address pairs, selects and arrival orders
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int o = 0; o < 3; o++) begin
                        if (o == 1) begin l_ce_n = c[0]; l_addr = AW'(a); step("R2 sweep pre"); end
                        if (o == 2) begin r_ce_n = c[1]; r_addr = AW'(b); step("R2 sweep pre"); end
                        l_ce_n = c[0]; l_addr = AW'(a); l_we_n = a[0];
                        r_ce_n = c[1]; r_addr = AW'(b); r_we_n = b[1];
                        repeat (3) step("R1 sweep");
                        idle(); repeat (2) step("R8 sweep idle");
                    end

        // R6 R7 R10: random traffic on a small address set
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                l_ce_n = 1'($urandom); l_addr = AW'($urandom_range(0, 2)); l_we_n = 1'($urandom);
            end
            if ($urandom_range(0, 3) == 0) begin
                r_ce_n = 1'($urandom); r_addr = AW'($urandom_range(0, 2)); r_we_n = 1'($urandom);
            end
            step("R6 R10 random");
        end
        idle(); repeat (3) step("idle");

        // R9: slave mode, busy inputs as write inhibits
        slave_mode = 1;
        for (int k = 0; k < 4; k++) begin
            l_busy_in_n = k[0]; r_busy_in_n = k[1];
            l_ce_n = 0; r_ce_n = 0; l_we_n = 0; r_we_n = 0;
            l_addr = 10'd7; r_addr = 10'd7;
            repeat (3) step("R9 slave");
            chk(l_wr_en == k[0] && r_wr_en == k[1], "R9 inhibit", l_wr_en, k[0]);
            chk(l_busy_n && r_busy_n, "R9 busy outs high", l_busy_n, 1);
            r_busy_in_n = ~r_busy_in_n; #1;
            chk(r_wr_en == !k[1], "R10 immediate inhibit", r_wr_en, !k[1]);
            idle(); repeat (2) step("R9 idle");
        end
        slave_mode = 0; l_busy_in_n = 1; r_busy_in_n = 1;
        repeat (3) step("idle");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule